// File: doc/BRIEF.md
# Bitplane Tile to Packed-Nibble Sliver Converter

The converter takes sprite tiles of 16x16 pixels at 4 bits per pixel, which arrive as bitplanes split across two ROM byte streams. It turns them into packed pixel rows. One stream, the odd ROM, carries bitplanes 0 and 1. The other, the even ROM, carries bitplanes 2 and 3. The two streams step through the same addresses, but each has its own valid/ready handshake, so one may run ahead of the other.

In the source layout a tile is stored as two 8-pixel-wide columns, with the right column stored first. Each 8x1 half-row is held as one byte per plane, and bit 0 of a plane byte is the leftmost pixel of that half. The block stores the whole right column. It then pairs each arriving left-column half-row with the stored right half of the same row. For each full row ("sliver") it emits one 64-bit little-endian word of 16 nibbles, and the 16 slivers of a tile leave in row order. Each tile consumes 64 bytes from each ROM and yields 128 bytes of output, which is twice one ROM's share.

Stalls at the output flow back to both input streams. No byte is dropped or reordered.

Top module: `tc_bitplane_tiler`

## Requirements
- R1: After reset, out_valid is 0 and both odd_ready and even_ready are 1.
- R2: In an output word, nibble k (bits 4k+3:4k) holds pixel k of the row, where pixel 0 is the leftmost. Within that nibble, bit p is the bit of bitplane p.
- R3: Per tile and per ROM, the first 32 bytes describe the right column (pixels 8..15) and the next 32 bytes describe the left column (pixels 0..7). Each column holds 2 bytes per row, rows 0..15 in order. Bit j of a plane byte is pixel j of its half, counted from the left of that half.
- R4: For each half-row, the odd stream supplies plane 0 and then plane 1, and the even stream supplies plane 2 and then plane 3.
- R5: Each tile yields exactly 16 output words, which give rows 0..15 in order with no gaps and no extra words.
- R6: No output word appears while a tile's right column is being received. Words appear only once left-column bytes for a row are present on both streams.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged on the next cycle.
- R8: The two input streams may be delayed or paced independently of each other, and the output is unchanged by this.
- R9: When the output is held stalled, the block stops accepting input: odd_ready and even_ready fall to 0 within a bounded time. No byte is lost, and the correct words appear once the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| odd_valid | input | 1 | Odd ROM byte valid |
| odd_data | input | 8 | Odd ROM byte (planes 0 and 1) |
| odd_ready | output | 1 | Odd ROM byte accepted when high with valid |
| even_valid | input | 1 | Even ROM byte valid |
| even_data | input | 8 | Even ROM byte (planes 2 and 3) |
| even_ready | output | 1 | Even ROM byte accepted when high with valid |
| out_valid | output | 1 | Sliver word valid |
| out_data | output | 64 | Packed 16-nibble sliver, pixel 0 in bits 3:0 |
| out_ready | input | 1 | Downstream accepts the sliver word |

## Verification
Two things can fall in the same cycle: the downstream takes the word held in the output register, and a completed left row loads the next word into that register. The bench provokes this by keeping out_ready high while both streams run without gaps, and again by toggling out_ready on alternate cycles across back-to-back tiles. The result is judged against a pixel-level reference that is built independently: any word that is lost, duplicated or swapped fails the row-by-row comparison and the final word count.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int TC_HALF_PX = 8;
    localparam int TC_PLANES  = 4;
    localparam int TC_ROWS    = 16;

    typedef enum logic {
        PH_RIGHT = 1'b0,
        PH_LEFT  = 1'b1
    } phase_e;
endpackage

// File: rtl/tc_rom_lane.sv
module tc_rom_lane #(
    parameter int BYTE_W = 8,
    parameter int BYTES  = 2,
    localparam int CNT_W = $clog2(BYTES + 1),
    localparam int PAIR_W = BYTE_W * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    input  logic              consume,
    output logic              full,
    output logic [PAIR_W-1:0] pair
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [PAIR_W-1:0] data;
    } lane_t;

    lane_t st_d, st_q;
    logic  take;

    always_comb begin
        st_d     = st_q;
        in_ready = (st_q.cnt < CNT_W'(BYTES));
        full     = (st_q.cnt == CNT_W'(BYTES));
        pair     = st_q.data;
        take     = in_valid && in_ready;
        if (take) begin
            for (int b = 0; b < BYTES; b++) begin
                if (st_q.cnt == CNT_W'(b)) begin
                    st_d.data[b*BYTE_W +: BYTE_W] = in_data;
                end
            end
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (consume && full) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: a completed group is held until the controller takes it
    a_r9_pair_held: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !consume) |=> full);
endmodule

// File: rtl/tc_row_store.sv
module tc_row_store #(
    parameter int ROWS   = 16,
    parameter int WORD_W = 32,
    localparam int AW = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_d [ROWS];
    logic [WORD_W-1:0] mem_q [ROWS];

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            mem_d[r] = mem_q[r];
        end
        if (we) begin
            mem_d[addr] = wdata;
        end
        rdata = mem_q[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem_q[r] <= '0;
            end
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                mem_q[r] <= mem_d[r];
            end
        end
    end
endmodule

// File: rtl/tc_sliver_pack.sv
module tc_sliver_pack #(
    parameter int HALF_PX = 8,
    parameter int PLANES  = 4,
    localparam int HALF_W = HALF_PX * PLANES,
    localparam int OUT_W  = 2 * HALF_W
) (
    input  logic [HALF_W-1:0] left_planes,
    input  logic [HALF_W-1:0] right_planes,
    output logic [OUT_W-1:0]  sliver
);
    // plane p byte sits at [p*HALF_PX +: HALF_PX]; bit k of it is pixel k of the half
    for (genvar h = 0; h < 2; h++) begin : g_half
        for (genvar k = 0; k < HALF_PX; k++) begin : g_px
            for (genvar p = 0; p < PLANES; p++) begin : g_pl
                if (h == 0) begin : g_l
                    assign sliver[(h*HALF_PX + k)*PLANES + p] = left_planes[p*HALF_PX + k];
                end else begin : g_r
                    assign sliver[(h*HALF_PX + k)*PLANES + p] = right_planes[p*HALF_PX + k];
                end
            end
        end
    end
endmodule

// File: rtl/tc_bitplane_tiler.sv
module tc_bitplane_tiler
    import tc_pkg::*;
#(
    parameter int HALF_PX = TC_HALF_PX,
    parameter int PLANES  = TC_PLANES,
    parameter int ROWS    = TC_ROWS,
    localparam int LANE_BYTES = PLANES / 2,
    localparam int LANE_W     = HALF_PX * LANE_BYTES,
    localparam int HALF_W     = HALF_PX * PLANES,
    localparam int OUT_W      = 2 * HALF_W,
    localparam int RW         = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               odd_valid,
    input  logic [HALF_PX-1:0] odd_data,
    output logic               odd_ready,
    input  logic               even_valid,
    input  logic [HALF_PX-1:0] even_data,
    output logic               even_ready,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_data,
    input  logic               out_ready
);
    typedef struct packed {
        phase_e           phase;
        logic [RW-1:0]    row;
        logic             ovalid;
        logic [OUT_W-1:0] odata;
    } ctl_t;

    ctl_t st_d, st_q;

    logic               ln_valid [2];
    logic [HALF_PX-1:0] ln_data  [2];
    logic               ln_ready [2];
    logic               ln_full  [2];
    logic [LANE_W-1:0]  ln_pair  [2];
    logic               consume;

    assign ln_valid[0] = odd_valid;
    assign ln_data[0]  = odd_data;
    assign ln_valid[1] = even_valid;
    assign ln_data[1]  = even_data;
    assign odd_ready   = ln_ready[0];
    assign even_ready  = ln_ready[1];

    // lane 0 = odd ROM (planes 0,1), lane 1 = even ROM (planes 2,3)
    for (genvar g = 0; g < 2; g++) begin : g_lane
        tc_rom_lane #(.BYTE_W(HALF_PX), .BYTES(LANE_BYTES)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (ln_valid[g]),
            .in_data  (ln_data[g]),
            .in_ready (ln_ready[g]),
            .consume  (consume),
            .full     (ln_full[g]),
            .pair     (ln_pair[g])
        );
    end

    logic [HALF_W-1:0] row_planes;
    logic [HALF_W-1:0] right_planes;
    logic [OUT_W-1:0]  packed_row;
    logic              both_full, slot_free, fire_right, fire_left;

    assign row_planes = {ln_pair[1], ln_pair[0]};

    tc_row_store #(.ROWS(ROWS), .WORD_W(HALF_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fire_right),
        .addr  (st_q.row),
        .wdata (row_planes),
        .rdata (right_planes)
    );

    tc_sliver_pack #(.HALF_PX(HALF_PX), .PLANES(PLANES)) u_pack (
        .left_planes  (row_planes),
        .right_planes (right_planes),
        .sliver       (packed_row)
    );

    always_comb begin
        st_d       = st_q;
        both_full  = ln_full[0] && ln_full[1];
        slot_free  = !st_q.ovalid || out_ready;
        fire_right = both_full && (st_q.phase == PH_RIGHT);
        fire_left  = both_full && (st_q.phase == PH_LEFT) && slot_free;
        consume    = fire_right || fire_left;

        if (out_ready) begin
            st_d.ovalid = 1'b0;
        end
        if (fire_left) begin
            st_d.ovalid = 1'b1;
            st_d.odata  = packed_row;
        end
        if (consume) begin
            if (st_q.row == RW'(ROWS - 1)) begin
                st_d.row   = '0;
                st_d.phase = (st_q.phase == PH_RIGHT) ? PH_LEFT : PH_RIGHT;
            end else begin
                st_d.row = st_q.row + RW'(1);
            end
        end
        out_valid = st_q.ovalid;
        out_data  = st_q.odata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_RIGHT, row: '0, ovalid: 1'b0, odata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a stalled word is neither dropped nor altered
    a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6: a fresh word is only ever produced while pairing left-column rows
    a_r6_emit_left_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(st_q.phase) == PH_LEFT));

    // R5: the column phase only turns over after the last row
    a_r5_phase_at_last_row: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != $past(st_q.phase)) |-> ($past(st_q.row) == RW'(ROWS - 1)));
endmodule

// File: tb/sim_tc_bitplane_tiler.sv
module sim_tc_bitplane_tiler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        odd_valid = 1'b0, even_valid = 1'b0;
    logic [7:0]  odd_data = '0, even_data = '0;
    logic        odd_ready, even_ready;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_ready = 1'b1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tc_bitplane_tiler u0 (
        .clk(clk), .rst_n(rst_n),
        .odd_valid(odd_valid), .odd_data(odd_data), .odd_ready(odd_ready),
        .even_valid(even_valid), .even_data(even_data), .even_ready(even_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    logic [3:0]  pix [16][16];
    logic [7:0]  odd_b [64];
    logic [7:0]  even_b [64];
    logic [63:0] exp_w [256];
    int          exp_n = 0;
    logic [63:0] got_w [256];
    int          got_n = 0;

    bit hold_out = 0;
    bit throttle = 0;
    bit tog = 0;
    bit prev_stall = 0;
    logic [63:0] prev_data = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // output side: drive out_ready, record transfers, watch stalled words (R7)
    always @(negedge clk) begin
        tog = ~tog;
        out_ready = hold_out ? 1'b0 : (throttle ? tog : 1'b1);
        if (rst_n) begin
            if (prev_stall) begin
                chk(out_valid && out_data == prev_data, "R7 stalled word held", out_data, prev_data);
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready && got_n < 256) begin
                got_w[got_n] = out_data;
                got_n++;
            end
        end
    end

    // build source bytes (R3, R4 layout) and expected words (R2) from pix
    task automatic build_tile();
        for (int h = 0; h < 2; h++) begin
            for (int r = 0; r < 16; r++) begin
                for (int i = 0; i < 2; i++) begin
                    logic [7:0] ob, eb;
                    int base;
                    base = (h == 0) ? 8 : 0;
                    for (int j = 0; j < 8; j++) begin
                        ob[j] = pix[r][base + j][i];
                        eb[j] = pix[r][base + j][2 + i];
                    end
                    odd_b[h*32 + r*2 + i]  = ob;
                    even_b[h*32 + r*2 + i] = eb;
                end
            end
        end
        for (int r = 0; r < 16; r++) begin
            logic [63:0] w;
            for (int k = 0; k < 16; k++) w[k*4 +: 4] = pix[r][k];
            exp_w[exp_n] = w;
            exp_n++;
        end
    endtask

    task automatic send_odd(input int from, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            bit ok;
            odd_valid = 1'b1;
            odd_data  = odd_b[from + i];
            do begin
                ok = odd_ready;
                @(negedge clk);
            end while (!ok);
            odd_valid = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic send_even(input int from, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            bit ok;
            even_valid = 1'b1;
            even_data  = even_b[from + i];
            do begin
                ok = even_ready;
                @(negedge clk);
            end while (!ok);
            even_valid = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic send_tile(input int ogap, input int egap, input int odelay);
        fork
            begin
                for (int d = 0; d < odelay; d++) @(negedge clk);
                send_odd(0, 64, ogap);
            end
            send_even(0, 64, egap);
        join
    endtask

    task automatic compare_words(input int start, input int n, input string tag);
        int t;
        t = 0;
        while (got_n < start + n && t < 4000) begin
            @(negedge clk);
            t++;
        end
        for (int i = 0; i < n; i++) begin
            chk(got_w[start + i] == exp_w[start + i], tag, got_w[start + i], exp_w[start + i]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
        chk(odd_ready && even_ready, "R1 input ready after reset", {62'd0, odd_ready, even_ready}, 64'd3);
    endtask

    task automatic t_column_ramp();
        int s;
        s = exp_n;
        for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) pix[r][c] = 4'(c);
        build_tile();
        send_tile(0, 0, 0);
        compare_words(s, 16, "R2 R3 column ramp");
    endtask

    task automatic t_row_order();
        int s;
        s = exp_n;
        for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) pix[r][c] = 4'(r);
        build_tile();
        send_tile(0, 0, 0);
        compare_words(s, 16, "R5 row order");
    endtask

    task automatic t_plane_probe();
        int s;
        s = exp_n;
        for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++)
            pix[r][c] = (c == r) ? 4'(1 << (r % 4)) : 4'd0;
        build_tile();
        send_tile(1, 0, 0);
        compare_words(s, 16, "R4 single plane probe");
    endtask

    task automatic t_right_only();
        int s, g0;
        s = exp_n;
        for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) pix[r][c] = 4'($urandom_range(0, 15));
        build_tile();
        g0 = got_n;
        fork
            send_odd(0, 32, 0);
            send_even(0, 32, 0);
        join
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R6 no word during right column", 64'(out_valid), 64'd0);
        end
        chk(got_n == g0, "R6 no words taken", 64'(got_n), 64'(g0));
        fork
            send_odd(32, 32, 0);
            send_even(32, 32, 2);
        join
        compare_words(s, 16, "R3 after split delivery");
    endtask

    task automatic t_skew();
        int s;
        s = exp_n;
        for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) pix[r][c] = 4'($urandom_range(0, 15));
        build_tile();
        send_tile(3, 0, 40);
        compare_words(s, 16, "R8 skewed streams");
    endtask

    task automatic t_stall();
        int s, g0;
        bit done;
        s = exp_n;
        done = 0;
        for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) pix[r][c] = 4'($urandom_range(0, 15));
        build_tile();
        g0 = got_n;
        hold_out = 1;
        fork
            begin
                send_tile(0, 0, 0);
                done = 1;
            end
        join_none
        repeat (400) @(negedge clk);
        chk(out_valid == 1'b1, "R9 word waiting", 64'(out_valid), 64'd1);
        chk(!odd_ready && !even_ready, "R9 inputs blocked", {62'd0, odd_ready, even_ready}, 64'd0);
        chk(got_n == g0, "R9 nothing taken while stalled", 64'(got_n), 64'(g0));
        hold_out = 0;
        compare_words(s, 16, "R9 words after stall");
        while (!done) @(negedge clk);
    endtask

    task automatic t_back_to_back();
        int s;
        s = exp_n;
        for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) pix[r][c] = 4'($urandom_range(0, 15));
        build_tile();
        send_tile(0, 0, 0);
        for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) pix[r][c] = 4'($urandom_range(0, 15));
        build_tile();
        throttle = 1;
        send_tile(0, 0, 0);
        compare_words(s, 32, "R5 R8 back-to-back tiles");
        throttle = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_column_ramp();
        t_row_order();
        t_plane_probe();
        t_right_only();
        t_skew();
        t_stall();
        t_back_to_back();
        repeat (20) @(negedge clk);
        chk(got_n == exp_n, "R5 total word count", 64'(got_n), 64'(exp_n));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule